// File: doc/BRIEF.md
# Floating Compare Condition-Code Unit

This block compares a source floating operand against an accumulator operand and turns the outcome into four condition bits: negative, zero, overflow and carry. Operands use a sign bit at the top, an excess-128 exponent of eight bits below it and a fraction in the remaining bits. A precision select chooses between a 64-bit double form and a 32-bit single form. In the single form only the upper half of each word is used.

A one-cycle start strobe launches a compare. Exactly one clock later the block raises a done pulse and presents the new condition bits, which then hold until the next compare. With done it may also raise a request to rewrite the accumulator as a clean zero. A source with its sign set and a zero exponent counts as an undefined variable. When the matching trap enable is on, such a source suppresses the compare and is flagged on a separate output.

Top module: `fcmp_cc_unit`

## Requirements
- R1: While reset is low at a clock edge, all condition bits, done, the zero-writeback request and the undefined flag are cleared to 0.
- R2: done is 1 in exactly the cycle after a cycle with start high, and 0 otherwise. Results appear in the same cycle as done.
- R3: An operand whose exponent field (bits 62:55) is zero is treated as all-zero bits, whatever its sign and fraction.
- R4: When the cleaned operands are bit-identical, Z becomes 1 and N, V and C become 0.
- R5: The zero-writeback request is 1 with done only when the cleaned operands are equal and both are zero. Otherwise it is 0.
- R6: When the cleaned operands differ, Z, V and C become 0 and N starts from the source sign (bit 63).
- R7: In the unequal case, N is inverted when source and accumulator signs match, the cleaned accumulator is nonzero and the source's bits 62:0, read as an unsigned number, are below the accumulator's.
- R8: With the precision select at 0 (single), bits 31:0 of both operands have no effect. With it at 1 (double), they take part in the compare.
- R9: A source with bit 63 set and exponent zero, while the undefined-trap enable is 1, leaves all four condition bits unchanged. It raises the undefined flag with done and gives a zero-writeback request of 0.
- R10: With the undefined-trap enable at 0, such a source is compared as a true zero and the undefined flag stays 0.
- R11: Without start, the condition bits keep their values, and the zero-writeback request and the undefined flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a compare using this cycle's operands |
| dbl_i | input | 1 | 1 = 64-bit double, 0 = 32-bit single (upper half) |
| undef_en_i | input | 1 | Trap enable for an undefined-variable source |
| src_i | input | 64 | Source operand |
| acc_i | input | 64 | Accumulator operand |
| cc_n_o | output | 1 | Negative condition bit |
| cc_z_o | output | 1 | Zero condition bit |
| cc_v_o | output | 1 | Overflow condition bit |
| cc_c_o | output | 1 | Carry condition bit |
| done_o | output | 1 | Result valid pulse, one cycle after start |
| zero_wr_o | output | 1 | Request to rewrite the accumulator as clean zero |
| undef_o | output | 1 | Compare suppressed by an undefined source |

## Verification
The assertions check several properties on every cycle. Done must follow start by exactly one clock. Z excludes N. A zero-writeback request never appears without Z. A suppressed compare and an idle cycle both leave the condition bits untouched. Equality and magnitude-less-than are never true together. Only the bench's scenarios can show the value of N. That covers the sign flip for matching signs, negative pairs where the larger magnitude means the smaller value, and a zero accumulator. The scenarios also cover dirty zeros with a nonzero fraction, single precision ignoring the low half, and the two settings of the undefined-trap enable.

// File: rtl/fcmp_pkg.sv
// Package: shared types for the floating compare condition-code unit.
// Assumes the four condition bits always travel together as one record.
package fcmp_pkg;

    // Condition-code record, most significant field first.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } fcmp_cc_t;

    // Condition codes for an equal compare.
    localparam fcmp_cc_t CC_EQUAL = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/fcmp_clean.sv
// Module: fcmp_clean
// Turns one raw operand into the form used for comparison. A zero
// exponent forces the whole word to zero. Single precision clears the
// low half. The module also reports whether the raw word is an
// undefined variable (sign set, exponent zero).
// Assumes the layout is sign at the top, exponent below it, then fraction.
module fcmp_clean #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 55
) (
    input  logic [EXP_W+FRAC_W:0] raw_i,
    input  logic                  dbl_i,
    output logic [EXP_W+FRAC_W:0] clean_o,
    output logic                  undef_o
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int LOW_W = W / 2;
    localparam int EXP_T = W - 2;

    logic exp_zero;

    // Detect a zero exponent field in the raw word.
    always_comb begin
        exp_zero = (raw_i[EXP_T -: EXP_W] == '0);
    end

    // Flag a negative word whose exponent is zero.
    always_comb begin
        undef_o = raw_i[W-1] & exp_zero;
    end

    // Produce the cleaned operand for the comparator.
    always_comb begin
        if (exp_zero) begin
            clean_o = '0;
        end else if (!dbl_i) begin
            clean_o = {raw_i[W-1:LOW_W], {LOW_W{1'b0}}};
        end else begin
            clean_o = raw_i;
        end
    end

endmodule

// File: rtl/fcmp_order.sv
// Module: fcmp_order
// Compares two cleaned operands. It gives equality, whether both are
// zero, the unsigned magnitude less-than of source against accumulator,
// and the resulting N value for the unequal case.
// Assumes both inputs already have dirty zeros removed.
module fcmp_order #(
    parameter int W = 64
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] acc_i,
    output logic         eq_o,
    output logic         both_zero_o,
    output logic         mag_lt_o,
    output logic         n_o
);
    logic same_sign;
    logic acc_nz;

    // Equality and zero detection over the full word.
    always_comb begin
        eq_o        = (src_i == acc_i);
        both_zero_o = (src_i == '0) && (acc_i == '0);
        acc_nz      = (acc_i != '0);
    end

    // Magnitude ordering of exponent and fraction, read as unsigned.
    always_comb begin
        mag_lt_o  = (src_i[W-2:0] < acc_i[W-2:0]);
        same_sign = (src_i[W-1] == acc_i[W-1]);
    end

    // N starts from the source sign, flipped when same sign and smaller.
    always_comb begin
        n_o = src_i[W-1] ^ (same_sign & acc_nz & mag_lt_o);
    end

endmodule

// File: rtl/fcmp_cc_unit.sv
// Module: fcmp_cc_unit (top)
// Registered floating compare. On start it cleans both operands and
// compares them. One cycle later it presents the condition bits, a
// done pulse, a clean-zero writeback request and the undefined flag.
// Assumes start is a single-cycle strobe and that operands are valid
// in the start cycle. The condition bits hold between compares.
module fcmp_cc_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 55
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  dbl_i,
    input  logic                  undef_en_i,
    input  logic [EXP_W+FRAC_W:0] src_i,
    input  logic [EXP_W+FRAC_W:0] acc_i,
    output logic                  cc_n_o,
    output logic                  cc_z_o,
    output logic                  cc_v_o,
    output logic                  cc_c_o,
    output logic                  done_o,
    output logic                  zero_wr_o,
    output logic                  undef_o
);
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int N_OPND = 2;

    logic [W-1:0] raw_w   [N_OPND];
    logic [W-1:0] clean_w [N_OPND];
    logic         undef_w [N_OPND];

    logic     ord_eq, ord_zero, ord_lt, ord_n;
    fcmp_cc_t cc_q;
    logic     done_q, zero_wr_q, undef_q;

    // Operand index 0 is the source, 1 is the accumulator.
    always_comb begin
        raw_w[0] = src_i;
        raw_w[1] = acc_i;
    end

    // One cleaner per operand.
    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_clean
        fcmp_clean #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) clean_i (
            .raw_i  (raw_w[gi]),
            .dbl_i  (dbl_i),
            .clean_o(clean_w[gi]),
            .undef_o(undef_w[gi])
        );
    end

    fcmp_order #(
        .W(W)
    ) order_i (
        .src_i      (clean_w[0]),
        .acc_i      (clean_w[1]),
        .eq_o       (ord_eq),
        .both_zero_o(ord_zero),
        .mag_lt_o   (ord_lt),
        .n_o        (ord_n)
    );

    // Result registers: update the codes on start, pulse done and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q      <= '0;
            done_q    <= 1'b0;
            zero_wr_q <= 1'b0;
            undef_q   <= 1'b0;
        end else begin
            done_q    <= start_i;
            zero_wr_q <= 1'b0;
            undef_q   <= 1'b0;
            if (start_i) begin
                if (undef_w[0] && undef_en_i) begin
                    undef_q <= 1'b1;
                end else if (ord_eq) begin
                    cc_q      <= CC_EQUAL;
                    zero_wr_q <= ord_zero;
                end else begin
                    cc_q <= '{n: ord_n, z: 1'b0, v: 1'b0, c: 1'b0};
                end
            end
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        cc_n_o    = cc_q.n;
        cc_z_o    = cc_q.z;
        cc_v_o    = cc_q.v;
        cc_c_o    = cc_q.c;
        done_o    = done_q;
        zero_wr_o = zero_wr_q;
        undef_o   = undef_q;
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);                                             // R2
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i));                                      // R2
    AST_Z_EXCLUDES_N: assert property (@(posedge clk) disable iff (!rst_n)
        cc_z_o |-> !cc_n_o);                                             // R4
    AST_ZWR_NEEDS_Z: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr_o |-> (cc_z_o && done_o));                               // R5
    AST_EQ_EXCLUDES_LT: assert property (@(posedge clk) disable iff (!rst_n)
        ord_eq |-> !ord_lt);                                             // R7
    AST_UNDEF_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> ($stable(cc_q) && !zero_wr_o));                      // R9
    AST_IDLE_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(cc_q) && !zero_wr_o && !undef_o));          // R11

endmodule

// File: tb/fcmp_cc_unit_tb_top.sv
module fcmp_cc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic        undef_en_i = 1'b0;
    logic [63:0] src_i = '0;
    logic [63:0] acc_i = '0;
    logic cc_n_o, cc_z_o, cc_v_o, cc_c_o, done_o, zero_wr_o, undef_o;

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    bit    ended   = 0;

    always #4ns clk = ~clk;   // 125 MHz

    fcmp_cc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i),
        .undef_en_i(undef_en_i), .src_i(src_i), .acc_i(acc_i),
        .cc_n_o(cc_n_o), .cc_z_o(cc_z_o), .cc_v_o(cc_v_o), .cc_c_o(cc_c_o),
        .done_o(done_o), .zero_wr_o(zero_wr_o), .undef_o(undef_o)
    );

    // Reference model state: {n,z,v,c,done,zero_wr,undef}
    logic [6:0] m_q = '0;

    function automatic logic [63:0] mk(input bit s, input int e, input longint f);
        mk = {s, 8'(e), 55'(f)};
    endfunction

    function automatic logic [63:0] tidy(input logic [63:0] x, input bit dbl);
        logic [63:0] r;
        if (x[62:55] == 8'd0) r = 64'd0;
        else r = x;
        if (!dbl) r[31:0] = 32'd0;
        return r;
    endfunction

    // Behavioural model: the next state from inputs at a clock edge.
    always @(posedge clk) begin
        logic [63:0] s, a;
        logic n;
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            logic [6:0] nx;
            nx = {m_q[6:3], 3'b000};
            if (start_i) begin
                nx[2] = 1'b1;
                if (src_i[63] && src_i[62:55] == 0 && undef_en_i) begin
                    nx[0] = 1'b1;
                end else begin
                    s = tidy(src_i, dbl_i);
                    a = tidy(acc_i, dbl_i);
                    if (s == a) begin
                        nx[6:3] = 4'b0100;
                        nx[1]   = (s == 64'd0);
                    end else begin
                        n = s[63];
                        if (s[63] == a[63] && a != 0 && s[62:0] < a[62:0]) n = ~n;
                        nx[6:3] = {n, 3'b000};
                    end
                end
            end
            m_q <= nx;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        logic [6:0] got;
        got = {cc_n_o, cc_z_o, cc_v_o, cc_c_o, done_o, zero_wr_o, undef_o};
        if (rst_n && !ended) begin
            vectors++;
            if (got !== m_q) begin
                errors++;
                $display("FAIL %s: {n,z,v,c,done,zwr,undef} actual=%b expected=%b",
                         cur_req, got, m_q);
            end
        end
    end

    task automatic cmp(input logic [63:0] s, input logic [63:0] a,
                       input bit dbl, input bit en, input string tag);
        cur_req = tag;
        @(posedge clk); #1ns;
        start_i = 1'b1; src_i = s; acc_i = a; dbl_i = dbl; undef_en_i = en;
        @(posedge clk); #1ns;
        start_i = 1'b0;
        src_i = ~s; acc_i = a ^ 64'h5a5a;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        vectors++;
        // R1: reset state
        if ({cc_n_o, cc_z_o, cc_v_o, cc_c_o, done_o, zero_wr_o, undef_o} !== 7'd0) begin
            errors++;
            $display("FAIL R1: reset outputs actual=%b expected=0000000",
                     {cc_n_o, cc_z_o, cc_v_o, cc_c_o, done_o, zero_wr_o, undef_o});
        end
        #1ns rst_n = 1'b1;

        cmp(mk(0,129,5), mk(0,129,5), 1, 0, "R4 R2");
        cmp(mk(1,140,77), mk(1,140,77), 1, 1, "R4");
        cmp(64'd0, 64'd0, 1, 0, "R5");
        cmp(mk(0,0,123), mk(1,0,7), 1, 0, "R3 R5");
        cmp(mk(0,0,9), mk(0,130,1), 1, 0, "R3");
        cmp(mk(0,129,3), mk(0,129,3), 1, 0, "R5 nonzero");
        cmp(mk(1,130,0), mk(0,130,0), 1, 0, "R6");
        cmp(mk(0,130,0), mk(1,130,0), 1, 0, "R6");
        cmp(mk(0,129,0), mk(0,130,0), 1, 0, "R7");
        cmp(mk(0,131,0), mk(0,130,0), 1, 0, "R7");
        cmp(mk(1,129,0), mk(1,130,0), 1, 0, "R7");
        cmp(mk(1,131,0), mk(1,130,0), 1, 0, "R7");
        cmp(mk(0,130,4), mk(0,130,9), 1, 0, "R7");
        cmp(mk(0,129,0), 64'd0, 1, 0, "R7");
        cmp(mk(1,129,0), mk(0,0,3), 1, 0, "R7");
        cmp(mk(0,129,5) | 64'h1234, mk(0,129,5), 0, 0, "R8");
        cmp(mk(0,129,5) | 64'h1234, mk(0,129,5), 1, 0, "R8");
        cmp(mk(1,128,0), mk(0,128,0), 1, 0, "R9 setup");
        cmp(mk(1,0,3), 64'd0, 1, 1, "R9");
        cmp(mk(1,0,3), 64'd0, 1, 0, "R10");
        cmp(mk(1,0,3), mk(0,129,0), 0, 0, "R10");
        cur_req = "R11";
        repeat (6) begin
            @(posedge clk); #1ns;
            src_i = {$urandom, $urandom}; acc_i = {$urandom, $urandom};
            dbl_i = ~dbl_i; undef_en_i = ~undef_en_i;
        end
        for (int i = 0; i < 300; i++) begin
            logic [63:0] s, a;
            s = mk(1'($urandom), 127 + $urandom % 4, $urandom % 4);
            a = ($urandom % 3 == 0) ? s : mk(1'($urandom), 127 + $urandom % 4, $urandom % 4);
            if ($urandom % 5 == 0) s[62:55] = 8'd0;
            if ($urandom % 2 == 0) s[31:0] = $urandom;
            cmp(s, a, 1'($urandom), 1'($urandom), "R6 R7 random");
        end
        repeat (3) @(posedge clk);
        @(negedge clk); #1ns;
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8ns * 100000);
        if (!ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule